// File: doc/BRIEF.md
# UART Receive Flow-Control Gate

This block sits behind a UART receiver and decides when to ask the remote transmitter to pause. Each received character arrives as a one-cycle "character complete" strobe with its data byte. The character goes into an 8-entry receive FIFO. The block drives an active-low request-to-send output, `rts_no`. It raises that output (stop sending) when the number of stored characters reaches a programmable watermark, and it lowers it again when software reads enough characters to bring the count back under the watermark.

The count is compared with the watermark only after a character has been fully received and written. The remote transmitter therefore sees the stop request late, and may already have started one more character. To make room for that character, the effective watermark is capped at depth minus one. This keeps at least one slot free at the moment `rts_no` rises, so the late character is stored rather than lost.

Flow-controlled operation needs the FIFO. If flow control is enabled while the FIFO is disabled, the block holds `rts_no` high. If flow control is disabled, `rts_no` stays low.

Top module: `rx_flow_gate`

## Requirements
- R1: After reset, `rts_no` is 0, `count_o` is 0 and `ovr_o` is 0.
- R2: With `fc_en_i`=1 and `fifo_en_i`=1, `rts_no` goes to 1 at the same clock edge that stores the character bringing `count_o` to at least the effective watermark.
- R3: `rts_no` returns to 0 at the clock edge at which a read brings `count_o` below the effective watermark.
- R4: A `wmark_i` value above 7 is treated as 7. A character arriving after `rts_no` has risen at the capped watermark is still stored (count 8).
- R5: A character strobed while `count_o` is 8 and no read is made is dropped. The count stays 8, `rd_data_o` is unchanged, and `ovr_o` becomes 1.
- R6: `ovr_o` stays 1 until a cycle with `ovr_clr_i`=1. If a drop happens in the same cycle as the clear, the flag stays 1.
- R7: A write and a read in the same cycle, with the FIFO holding at least one entry (full included), leave `count_o` unchanged and store the new byte.
- R8: A read strobe while the FIFO is empty has no effect: `count_o` stays 0.
- R9: With `fc_en_i`=0, `rts_no` is 0 whatever the FIFO count.
- R10: With `fc_en_i`=1 and `fifo_en_i`=0, `rts_no` is 1 from the next edge. The FIFO is emptied (`count_o`=0), and strobed characters are dropped without setting `ovr_o`.
- R11: Characters leave in arrival order. `rd_data_o` shows the oldest stored byte before any read, and a read strobe removes it.
- R12: A change of `wmark_i` updates `rts_no` at the next clock edge, even when no character is written or read. A watermark of 0 keeps `rts_no` at 1 while flow control and the FIFO are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_done_i | input | 1 | One-cycle strobe: a character has been fully received |
| rx_data_i | input | 8 | Received character |
| rd_i | input | 1 | FIFO read (pop) strobe |
| wmark_i | input | 4 | Receive watermark; values above 7 are capped at 7 |
| fc_en_i | input | 1 | Receiver request-to-send mode enable |
| fifo_en_i | input | 1 | Receive FIFO enable |
| ovr_clr_i | input | 1 | Write-1 clear of the overrun flag |
| rts_no | output | 1 | Request-to-send, active low (1 = stop sending) |
| rd_data_o | output | 8 | Oldest stored character |
| count_o | output | 4 | Number of stored characters |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The assertions are checked on every cycle. They cover these rules: the count never goes past the depth; a drop at full leaves the count alone and sets the flag; a combined read and write leaves the count alone; a read from empty leaves the count alone; the flag stays set until cleared; and `rts_no` takes the forced levels when flow control or the FIFO is disabled. Only the directed scenarios can show the following: the exact edge at which `rts_no` rises and falls against the watermark, the cap at 7, storage of the late character after the stop request, data order through wrap-around, and the response to a watermark change made while the FIFO is idle.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned PTR_W      = $clog2(FIFO_DEPTH);

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;
endpackage

// File: rtl/rxfc_fifo.sv
module rxfc_fifo
  import rxfc_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned CW    = CNT_W,
  parameter int unsigned AW    = PTR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          ovr_clr_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          ovr_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q;
  logic          full, empty, rd_ok, wr_ok, drop;
  fifo_op_e      op;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign rd_ok = en_i && rd_i && !empty;
  // a read in the same cycle frees the slot the write needs
  assign wr_ok = en_i && wr_i && (!full || rd_ok);
  assign drop  = en_i && wr_i && full && !rd_ok;
  assign op    = fifo_op_e'({wr_ok, rd_ok});

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i) cnt_d = '0;
    else begin
      unique case (op)
        OP_PUSH: cnt_d = cnt_q + 1'b1;
        OP_POP:  cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (!en_i) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (wr_ok) wp_q <= inc_ptr(wp_q);
        if (rd_ok) rp_q <= inc_ptr(rp_q);
      end
      if (drop)           ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o   = mem_q[rp_q];
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign ovr_o     = ovr_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R5
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && !rd_i && cnt_q == FULL_CNT) |=> ($stable(cnt_q) && ovr_q)); // R5
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr_i) |=> ovr_q); // R6
  AST_WR_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_i && rd_i && cnt_q != '0) |=> $stable(cnt_q)); // R7
  AST_EMPTY_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && rd_i && !wr_i && cnt_q == '0) |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/rxfc_rts_gate.sv
module rxfc_rts_gate
  import rxfc_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned CW    = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fc_en_i,
  input  logic          fifo_en_i,
  input  logic [CW-1:0] wmark_i,
  input  logic [CW-1:0] cnt_nxt_i,
  output logic          rts_no
);
  // cap leaves one slot for a character already on the wire
  localparam logic [CW-1:0] WM_MAX = CW'(DEPTH - 1);

  logic [CW-1:0] wm_eff;
  logic          stop_d, stop_q;

  assign wm_eff = (wmark_i > WM_MAX) ? WM_MAX : wmark_i;

  always_comb begin
    if (!fc_en_i)        stop_d = 1'b0;
    else if (!fifo_en_i) stop_d = 1'b1;
    else                 stop_d = (cnt_nxt_i >= wm_eff);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stop_q <= 1'b0;
    else         stop_q <= stop_d;
  end

  assign rts_no = stop_q;

  AST_RTS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fc_en_i |=> !rts_no); // R9
  AST_NOFIFO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_en_i && !fifo_en_i) |=> rts_no); // R10
endmodule

// File: rtl/rx_flow_gate.sv
module rx_flow_gate
  import rxfc_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  parameter int unsigned DW    = DATA_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_done_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rd_i,
  input  logic [CW-1:0] wmark_i,
  input  logic          fc_en_i,
  input  logic          fifo_en_i,
  input  logic          ovr_clr_i,
  output logic          rts_no,
  output logic [DW-1:0] rd_data_o,
  output logic [CW-1:0] count_o,
  output logic          ovr_o
);
  logic [CW-1:0] cnt_nxt;

  rxfc_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW), .AW(AW)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (fifo_en_i),
    .wr_i      (rx_done_i),
    .wdata_i   (rx_data_i),
    .rd_i      (rd_i),
    .ovr_clr_i (ovr_clr_i),
    .rdata_o   (rd_data_o),
    .cnt_o     (count_o),
    .cnt_nxt_o (cnt_nxt),
    .ovr_o     (ovr_o)
  );

  rxfc_rts_gate #(.DEPTH(DEPTH), .CW(CW)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fc_en_i   (fc_en_i),
    .fifo_en_i (fifo_en_i),
    .wmark_i   (wmark_i),
    .cnt_nxt_i (cnt_nxt),
    .rts_no    (rts_no)
  );

  AST_NOFIFO_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> (count_o == '0)); // R10
endmodule

// File: tb/sim_rx_flow_gate.sv
module sim_rx_flow_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_done = 1'b0, rd = 1'b0, fc_en = 1'b0, fifo_en = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rx_data = '0;
  logic [3:0] wmark = '0;
  logic       rts_n, ovr;
  logic [7:0] rd_data;
  logic [3:0] count;

  int n_run = 0, n_fail = 0;
  logic [7:0] q[$];

  always #4 clk = ~clk;

  rx_flow_gate u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_done_i(rx_done), .rx_data_i(rx_data),
    .rd_i(rd), .wmark_i(wmark), .fc_en_i(fc_en), .fifo_en_i(fifo_en),
    .ovr_clr_i(ovr_clr), .rts_no(rts_n), .rd_data_o(rd_data),
    .count_o(count), .ovr_o(ovr)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, release after posedge
  task automatic step(bit w, logic [7:0] d, bit r, bit c);
    bit popped;
    @(negedge clk);
    rx_done = w; rx_data = d; rd = r; ovr_clr = c;
    @(posedge clk);
    #1;
    rx_done = 0; rd = 0; ovr_clr = 0;
    if (fifo_en) begin
      popped = r && q.size() > 0;
      if (popped) void'(q.pop_front());
      if (w && q.size() < 8) q.push_back(d);
    end else q.delete();
  endtask

  task automatic pop_chk(string req);
    chk(req, "head data", rd_data, q[0]);
    step(0, 0, 1, 0);
  endtask

  task automatic t_reset();
    chk("R1", "rts", rts_n, 0);
    chk("R1", "count", count, 0);
    chk("R1", "ovr", ovr, 0);
  endtask

  task automatic t_threshold();
    fc_en = 1; fifo_en = 1; wmark = 4;
    step(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step(1, 8'h10 + 8'(i), 0, 0);
      chk("R2", "rts below wm", rts_n, 0);
    end
    step(1, 8'h13, 0, 0);
    chk("R2", "rts at wm", rts_n, 1);
    chk("R2", "count at wm", count, 4);
    step(1, 8'h14, 0, 0);
    chk("R4", "late char stored", count, 5);
    pop_chk("R11");
    chk("R3", "rts still high", rts_n, 1);
    pop_chk("R11");
    chk("R3", "rts low below wm", rts_n, 0);
    chk("R3", "count", count, 3);
    while (q.size() > 0) pop_chk("R11");
    chk("R11", "drained", count, 0);
  endtask

  task automatic t_clamp();
    wmark = 4'd12;
    step(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, 8'hA0 + 8'(i), 0, 0);
    chk("R4", "rts at 6", rts_n, 0);
    step(1, 8'hA6, 0, 0);
    chk("R4", "rts at capped wm 7", rts_n, 1);
    step(1, 8'hA7, 0, 0);
    chk("R4", "late char to 8", count, 8);
    step(1, 8'hEE, 0, 0);
    chk("R5", "count held", count, 8);
    chk("R5", "ovr set", ovr, 1);
    chk("R5", "head unchanged", rd_data, 8'hA0);
    step(1, 8'hB0, 1, 0);
    chk("R7", "count full wr+rd", count, 8);
    chk("R7", "head advanced", rd_data, 8'hA1);
    step(1, 8'hEF, 0, 1);
    chk("R6", "drop beats clear", ovr, 1);
    step(0, 0, 0, 0);
    chk("R6", "sticky", ovr, 1);
    step(0, 0, 0, 1);
    chk("R6", "cleared", ovr, 0);
    step(1, 8'hB1, 1, 0);
    chk("R7", "count mid wr+rd", count, 8);
    while (q.size() > 0) pop_chk("R11");
    chk("R3", "rts low empty", rts_n, 0);
  endtask

  task automatic t_empty_read();
    step(0, 0, 1, 0);
    chk("R8", "count after empty rd", count, 0);
    chk("R8", "ovr", ovr, 0);
  endtask

  task automatic t_wm_change();
    wmark = 4;
    step(1, 8'h31, 0, 0);
    step(1, 8'h32, 0, 0);
    chk("R12", "rts at 2 of 4", rts_n, 0);
    @(negedge clk); wmark = 2;
    @(posedge clk); #1;
    chk("R12", "rts after wm drop", rts_n, 1);
    @(negedge clk); wmark = 3;
    @(posedge clk); #1;
    chk("R12", "rts after wm raise", rts_n, 0);
    pop_chk("R11"); pop_chk("R11");
    @(negedge clk); wmark = 0;
    @(posedge clk); #1;
    chk("R12", "wm 0 empty", rts_n, 1);
  endtask

  task automatic t_mode_off();
    fc_en = 0; wmark = 2;
    for (int i = 0; i < 8; i++) step(1, 8'(i), 0, 0);
    chk("R9", "count full", count, 8);
    chk("R9", "rts low mode off", rts_n, 0);
  endtask

  task automatic t_fifo_off();
    fc_en = 1; fifo_en = 0;
    step(0, 0, 0, 0);
    chk("R10", "rts high no fifo", rts_n, 1);
    chk("R10", "flushed", count, 0);
    step(1, 8'h55, 0, 0);
    chk("R10", "write dropped", count, 0);
    chk("R10", "no overrun", ovr, 0);
    fifo_en = 1; wmark = 3;
    step(1, 8'h66, 0, 0);
    chk("R11", "after flush head", rd_data, 8'h66);
    chk("R3", "rts low below wm", rts_n, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    t_threshold();
    t_clamp();
    t_empty_read();
    t_wm_change();
    t_mode_off();
    t_fifo_off();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule